// File: doc/BRIEF.md
# Four-Phase Boot Word Receiver

This block is the receiving end of an asynchronous four-phase handshake through which a loader pulls boot words from a host, one word at a time. The loader asks for a word on a valid/ready request channel. The block then waits for the host to pull its active-low ready line. While it waits, it sends out a periodic one-cycle pulse on a separate indicator pin, which tells the host that the receiver is waiting for data. The host ready line is asynchronous, so it goes through a synchroniser first.

When the synchronised ready line is seen low, the block samples the host data bus on the next clock edge. It hands the word to the loader with a one-cycle strobe and, at the same edge, pulls its active-low acknowledge line. It then waits for the host to release ready, which means the data is no longer valid. It releases acknowledge to close the transfer, and only then does it accept the next request.

Request back-pressure works as follows. `req_ready` is high only when the block is idle with acknowledge released. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The word output has no back-pressure: the loader must take `word_data` in the cycle `word_valid` is high.

Top module: `boot_hs_rx`

## Requirements
- R1: After reset, `ack_n` is 1, `wait_pulse` is 0, `word_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while idle. A request taken with `req_valid`=1 drops `req_ready` to 0 from the next cycle onward, until the transfer completes.
- R3: While waiting for the host, `wait_pulse` is 1 for exactly one cycle in every 8. The first pulse falls in the first waiting cycle.
- R4: `wait_pulse` is 0 whenever the block is not waiting. Once the synchronised ready line is seen low, pulsing stops.
- R5: If `host_rdy_n` falls just before clock edge k, the bus is sampled at edge k+3. That value appears on `word_data`, with `word_valid` high for exactly one cycle after that edge.
- R6: `ack_n` goes to 0 at the same edge that raises `word_valid`. It stays 0 while `host_rdy_n` is held low.
- R7: If `host_rdy_n` rises just before edge k, `ack_n` returns to 1 after edge k+2. While `ack_n` is 0, `req_valid` is not accepted.
- R8: When no request is pending, activity on `host_rdy_n` is ignored. `ack_n` stays 1, `word_valid` stays 0 and no pulse is emitted.
- R9: Words in successive transfers are delivered in the order the host offered them, one per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Loader asks for one word |
| req_ready | output | 1 | Block idle, request can be taken |
| host_rdy_n | input | 1 | Host data-ready, active low, asynchronous |
| host_data | input | DATA_W | Host data bus |
| ack_n | output | 1 | Acknowledge to host, active low |
| wait_pulse | output | 1 | Waiting indicator pulse |
| word_valid | output | 1 | One-cycle strobe, captured word present |
| word_data | output | DATA_W | Captured word |

## Verification
The assertions assume the host follows the protocol. It pulls ready low only while a request is pending and acknowledge is high. It holds the data bus stable from the fall of ready until acknowledge goes low. It releases ready only after acknowledge has dropped. The stimulus drives the host side as a four-phase agent that waits on `ack_n` before each edge it makes. The only ready activity outside a request is an idle burst that checks R8, and that burst returns ready high before the next request.

// File: rtl/boot_hs_pkg.sv
package boot_hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_TAKE = 2'd2,
    HS_DROP = 2'd3
  } hs_state_e;
endpackage

// File: rtl/boot_hs_sync.sv
module boot_hs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/boot_hs_pulse.sv
module boot_hs_pulse #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic pulse
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase_q <= '0;
    else if (!enable)       phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign pulse = enable && (phase_q == '0);
endmodule

// File: rtl/boot_hs_rx.sv
module boot_hs_rx
  import boot_hs_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_PERIOD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              host_rdy_n,
  input  logic [DATA_W-1:0] host_data,
  output logic              ack_n,
  output logic              wait_pulse,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data
);
  hs_state_e         state_q, state_d;
  logic              rdy_n_s;
  logic              ack_n_q;
  logic              valid_q;
  logic [DATA_W-1:0] word_q;

  boot_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (host_rdy_n),
    .q_sync  (rdy_n_s)
  );

  boot_hs_pulse #(.PERIOD(PULSE_PERIOD)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (state_q == HS_WAIT),
    .pulse  (wait_pulse)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (req_valid) state_d = HS_WAIT;
      HS_WAIT: if (!rdy_n_s)  state_d = HS_TAKE;
      HS_TAKE:                state_d = HS_DROP;
      HS_DROP: if (rdy_n_s)   state_d = HS_IDLE;
      default:                state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      ack_n_q <= 1'b1;
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= (state_q == HS_TAKE);
      if (state_q == HS_TAKE) begin
        word_q  <= host_data;
        ack_n_q <= 1'b0;
      end else if (state_q == HS_DROP && rdy_n_s) begin
        ack_n_q <= 1'b1;
      end
    end
  end

  assign req_ready  = (state_q == HS_IDLE);
  assign ack_n      = ack_n_q;
  assign word_valid = valid_q;
  assign word_data  = word_q;
endmodule

// File: rtl/boot_hs_rx_chk.sv
module boot_hs_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ack_n,
  input logic wait_pulse,
  input logic word_valid
);
  // R2, R8: idle means acknowledge released and no pulse
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ack_n && !wait_pulse));

  // R7: request not accepted while acknowledge is low
  a_r7_no_req_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && req_valid) |=> !req_ready);

  // R4: no pulse while acknowledge is held
  a_r4_quiet_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !wait_pulse);

  // R5: strobe lasts one cycle
  a_r5_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R6: acknowledge falls together with the strobe
  a_r6_ack_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> word_valid);

  // R3: pulse is a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wait_pulse |=> !wait_pulse);
endmodule

bind boot_hs_rx boot_hs_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ack_n      (ack_n),
  .wait_pulse (wait_pulse),
  .word_valid (word_valid)
);

// File: tb/boot_hs_rx_bench.sv
`timescale 1ns/1ps
module boot_hs_rx_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          host_rdy_n = 1'b1;
  logic [DW-1:0] host_data = '0;
  logic          ack_n, wait_pulse, word_valid;
  logic [DW-1:0] word_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  boot_hs_rx u_boot_hs_rx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .host_rdy_n(host_rdy_n), .host_data(host_data), .ack_n(ack_n),
    .wait_pulse(wait_pulse), .word_valid(word_valid), .word_data(word_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected word", 64'(word_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(word_data == e, "R9 word order/value", 64'(word_data), 64'(e));
      end
    end
  end

  task automatic request();
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready drops after accept", 64'(req_ready), 0);
  endtask

  task automatic host_send(input logic [DW-1:0] w);
    int n;
    exp_q.push_back(w);
    host_data = w;
    host_rdy_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (ack_n && n < 50);
    check(n == 4, "R5 capture latency", 64'(n), 4);
    req_valid = 1'b1;                       // R7 request during ack
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ack_n == 1'b0, "R6 ack held while ready low", 64'(ack_n), 0);
      check(req_ready == 1'b0, "R7 request refused during ack", 64'(req_ready), 0);
    end
    req_valid = 1'b0;
    host_rdy_n = 1'b1;
    host_data = ~w;
    n = 0;
    do begin @(negedge clk); n++; end while (!ack_n && n < 50);
    check(n == 3, "R7 release latency", 64'(n), 3);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "watchdog", 64'(cyc), 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ack_n == 1'b1, "R1 ack after reset", 64'(ack_n), 1);
    check(wait_pulse == 1'b0, "R1 pulse after reset", 64'(wait_pulse), 0);
    check(word_valid == 1'b0, "R1 strobe after reset", 64'(word_valid), 0);
    check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
    rst_n = 1'b1;

    // R8: host activity with no request pending
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); host_rdy_n = 1'b0; host_data = 32'hBAD0_0000 + 32'(i);
      repeat (5) @(negedge clk);
      check(ack_n == 1'b1 && word_valid == 1'b0 && wait_pulse == 1'b0,
            "R8 idle ready ignored", {61'd0, ack_n, word_valid, wait_pulse}, 64'h4);
      host_rdy_n = 1'b1;
    end
    repeat (4) @(negedge clk);

    // R3: pulse cadence while waiting
    begin
      int pulses;
      int first;
      request();
      // request() already sampled the first waiting cycle; count from there
      pulses = 0; first = -1;
      for (int i = 0; i < 31; i++) begin
        if (wait_pulse) begin pulses++; if (first < 0) first = i; end
        @(negedge clk);
      end
      check(first == 0, "R3 first pulse in first wait cycle", 64'(first), 0);
      check(pulses == 4, "R3 one pulse per 8 cycles", 64'(pulses), 4);
      host_send(32'hCAFE_0001);
      check(wait_pulse == 1'b0, "R4 pulse stops after transfer", 64'(wait_pulse), 0);
    end

    // R9: several words in sequence with varied patterns
    for (int k = 0; k < 6; k++) begin
      request();
      repeat (k * 3) @(negedge clk);
      host_send(32'h1357_9BDF ^ (32'h0101_0101 << k) ^ 32'(k));
    end
    request();
    host_send(32'h0000_0000);
    request();
    host_send(32'hFFFF_FFFF);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9 all words delivered", 64'(exp_q.size()), 0);
    check(ack_n == 1'b1 && req_ready == 1'b1, "R7 idle at end",
          {62'd0, ack_n, req_ready}, 64'h3);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule